// File: doc/BRIEF.md
# I2C Register Slave with Coherent Time Snapshot

This block is an I2C target that lets a bus controller read and write a bank of byte locations through a register pointer that advances on its own. The controller first writes the pointer. Each later byte in a write is stored at the pointer and sent out on a one-cycle write strobe. A read streams bytes out from the pointer onward.

The low locations hold timekeeping data, and a live clock keeps changing them. To keep a multi-byte read coherent, the block copies all of them into a shadow bank at every START, and reads of that region are served from the copy. The other locations are kept inside the block.

SCL and SDA arrive as raw pins and are sampled in the system clock domain. The block drives the bus only through an open-drain pull-down enable. If SCL stays low for longer than a configurable number of cycles while a transfer is open, the interface drops back to idle and ignores all traffic until the next START.

Top module: `i2c_regbank_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) opens a transfer from any state. A STOP (SDA rising while SCL is high) returns the block to idle with SDA released, and bytes clocked after a STOP get no ACK.
- R2: The first byte after a START is compared against the 7-bit device address 7'b1101000 in bits 7..1. Bit 0 selects the direction: 0 is write, 1 is read. Bytes travel MSB first. A matching address byte is acknowledged by holding `sda_pull` high through the ninth SCL pulse.
- R3: An address byte that does not match gets no ACK. No write strobe follows, and the block ignores all bytes until the next START.
- R4: In a write, the first byte after the address loads the pointer. Each later byte produces a single-cycle `wr_en` with `wr_addr` equal to the pointer and `wr_data` equal to the byte, after which the pointer increments. Every byte of a write is ACKed.
- R5: In a read, the block sends the byte at the pointer MSB first, pulling SDA low for each 0 bit, and increments the pointer after each byte.
- R6: When the controller NACKs a read byte, the block releases SDA and sends nothing more until the next START.
- R7: A repeated START ends the current transfer and starts a new address phase, and the pointer is kept.
- R8: Every START copies `time_live` into the shadow bank (location i takes bits 8i+7..8i) and pulses `snap_load` for one cycle. Reads of locations below TIME_REGS return that copy, even if `time_live` changes afterwards.
- R9: Reads of locations at or above TIME_REGS return the last byte written there.
- R10: The pointer wraps from location 2^ADDR_W-1 to location 0.
- R11: If SCL stays low for TIMEOUT_CYC system cycles while a transfer is open, the block releases SDA and goes idle. It then ignores all bytes until the next START.
- R12: After reset, `sda_pull`, `wr_en` and `snap_load` are 0, the pointer is 0 and every stored location is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL level from the bus |
| sda_i | input | 1 | Raw SDA level from the bus |
| time_live | input | TIME_REGS*8 | Live timekeeping bytes; byte i is bits 8i+7..8i |
| sda_pull | output | 1 | When 1, the pad pulls SDA low |
| wr_en | output | 1 | One-cycle strobe for a received data byte |
| wr_addr | output | ADDR_W | Location of the byte being written |
| wr_data | output | 8 | Byte being written |
| snap_load | output | 1 | One-cycle pulse when the shadow bank is loaded at a START |

## Verification
The bench builds the block with TIMEOUT_CYC set to 200, so the SCL-low timeout fires after a short stall in the middle of an ACK while ordinary SCL low phases stay well below it. It keeps ADDR_W at 6 and TIME_REGS at 8. With those values the wrap from location 63 to 0 happens within a short write, and reads cross from stored locations into the shadowed time region. The timekeeping input is changed after each START and between bytes of a read, so a read that leaked live values would miscompare.

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'b1101000,
  parameter int         ADDR_W      = 6,
  parameter int         TIME_REGS   = 8,
  parameter int         TIMEOUT_CYC = 1750000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  input  logic [TIME_REGS*8-1:0] time_live,
  output logic                   sda_pull,
  output logic                   wr_en,
  output logic [ADDR_W-1:0]      wr_addr,
  output logic [7:0]             wr_data,
  output logic                   snap_load
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SH_W  = $clog2(TIME_REGS);
  localparam int TO_W  = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TO_W-1:0]   TO_LIM   = TO_W'(TIMEOUT_CYC);
  localparam logic [ADDR_W:0]   TIME_LIM = (ADDR_W+1)'(TIME_REGS);

  typedef enum logic [2:0] {IDLE, DEV, PTR, WRD, RDD} st_t;

  st_t              st;
  logic [2:0]       scl_p, sda_p;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg, tx, rd_byte;
  logic [ADDR_W-1:0] ptr;
  logic             rw, mnack;
  logic [TO_W-1:0]  to_cnt;
  logic [7:0]       mem    [DEPTH];
  logic [7:0]       shadow [TIME_REGS];

  wire scl_s = scl_p[1];
  wire scl_d = scl_p[2];
  wire sda_s = sda_p[1];
  wire sda_d = sda_p[2];
  wire start_det = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  wire scl_rise  = scl_s & ~scl_d;
  wire scl_fall  = ~scl_s & scl_d;
  wire tmo       = (st != IDLE) && (to_cnt == TO_LIM);
  wire in_time   = {1'b0, ptr} < TIME_LIM;
  wire addr_hit  = shreg[7:1] == DEV_ADDR;

  always_comb rd_byte = in_time ? shadow[ptr[SH_W-1:0]] : mem[ptr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) to_cnt <= '0;
    else if (st == IDLE || scl_s) to_cnt <= '0;
    else if (to_cnt != TO_LIM) to_cnt <= to_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < TIME_REGS; i++) shadow[i] <= '0;
    end else if (start_det) begin
      for (int i = 0; i < TIME_REGS; i++) shadow[i] <= time_live[8*i +: 8];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      tx        <= '0;
      ptr       <= '0;
      rw        <= 1'b0;
      mnack     <= 1'b0;
      sda_pull  <= 1'b0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      snap_load <= 1'b0;
    end else begin
      wr_en     <= 1'b0;
      snap_load <= 1'b0;
      if (start_det) begin
        st        <= DEV;
        bitcnt    <= '0;
        sda_pull  <= 1'b0;
        snap_load <= 1'b1;
      end else if (stop_det || tmo) begin
        st       <= IDLE;
        sda_pull <= 1'b0;
      end else if (st != IDLE) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8 && st != RDD) shreg <= {shreg[6:0], sda_s};
          if (bitcnt == 4'd8 && st == RDD) mnack <= sda_s;
          bitcnt <= bitcnt + 1'b1;
        end else if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            case (st)
              DEV: if (addr_hit) begin
                     sda_pull <= 1'b1;
                     rw       <= shreg[0];
                   end else st <= IDLE;
              PTR: begin
                     ptr      <= shreg[ADDR_W-1:0];
                     sda_pull <= 1'b1;
                   end
              WRD: begin
                     wr_en    <= 1'b1;
                     wr_addr  <= ptr;
                     wr_data  <= shreg;
                     ptr      <= ptr + 1'b1;
                     sda_pull <= 1'b1;
                   end
              default: begin
                     sda_pull <= 1'b0;
                     ptr      <= ptr + 1'b1;
                   end
            endcase
          end else if (bitcnt == 4'd9) begin
            bitcnt   <= '0;
            sda_pull <= 1'b0;
            case (st)
              DEV: if (rw) begin
                     st       <= RDD;
                     tx       <= rd_byte;
                     sda_pull <= ~rd_byte[7];
                   end else st <= PTR;
              PTR: st <= WRD;
              RDD: if (mnack) st <= IDLE;
                   else begin
                     tx       <= rd_byte;
                     sda_pull <= ~rd_byte[7];
                   end
              default: ;
            endcase
          end else if (st == RDD && bitcnt != 4'd0) begin
            sda_pull <= ~tx[3'd7 - bitcnt[2:0]];
          end
        end
      end
    end

  assert_snap_after_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> snap_load);

  assert_pull_moves_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> !scl_s);

  assert_timeout_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> (st == IDLE && !sda_pull));

  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  assert_miss_no_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == DEV && scl_fall && bitcnt == 4'd8 && !addr_hit && !start_det && !stop_det && !tmo)
      |=> (st == IDLE && !sda_pull));
endmodule

// File: tb/i2c_regbank_slave_bench.sv
module i2c_regbank_slave_bench;
  localparam int AW = 6;
  localparam int TR = 8;
  localparam int TO = 200;
  localparam int Q  = 8;
  localparam logic [6:0] DEV = 7'b1101000;

  logic clk = 0, rst_n = 0, scl = 1, sda_m = 1;
  logic [TR*8-1:0] tl = 64'h5948_3726_1504_f3e2;
  logic sda_pull, wr_en, snap_load;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;
  wire sda_bus = sda_m & ~sda_pull;

  i2c_regbank_slave #(.ADDR_W(AW), .TIME_REGS(TR), .TIMEOUT_CYC(TO)) u_i2c_regbank_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .time_live(tl),
    .sda_pull(sda_pull), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .snap_load(snap_load));

  always #5 clk = ~clk;

  int nchk = 0, nerr = 0, snaps = 0, exp_snaps = 0, ptr_m = 0;
  bit done = 0;
  logic [7:0] mem_m [64];
  logic [7:0] shadow_m [TR];
  logic [AW+7:0] exp_q [$];

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (snap_load) snaps++;
    if (wr_en) begin
      if (exp_q.size() == 0) chk("R4 unexpected write strobe", 1, 0);
      else begin
        logic [AW+7:0] e;
        e = exp_q.pop_front();
        chk("R4 write address/data", int'({wr_addr, wr_data}), int'(e));
      end
    end
  end

  task automatic hq(); repeat (Q) @(negedge clk); endtask

  task automatic do_start();
    sda_m = 1; hq(); scl = 1; hq();
    for (int i = 0; i < TR; i++) shadow_m[i] = tl[8*i +: 8];
    sda_m = 0; hq(); scl = 0; hq();
    exp_snaps++;
    chk("R8 snapshot pulse count", snaps, exp_snaps);
    tl = {tl[55:0], tl[63:56]} + 64'h1111_1111_1111_1111;
  endtask

  task automatic do_stop();
    sda_m = 0; hq(); scl = 1; hq(); sda_m = 1; hq();
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; hq(); scl = 1; hq(); s = sda_bus; hq(); scl = 0; hq();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
    clk_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); d[i] = s; end
    clk_bit(!mack, s);
  endtask

  task automatic dev(input logic rw, input string req);
    logic a;
    send_byte({DEV, rw}, a);
    chk(req, int'(a), 1);
  endtask

  task automatic setptr(input int p);
    logic a;
    send_byte(8'(p), a);
    chk("R4 pointer byte ACK", int'(a), 1);
    ptr_m = p;
  endtask

  task automatic wbyte(input logic [7:0] d);
    logic a;
    exp_q.push_back({AW'(ptr_m), d});
    mem_m[ptr_m] = d;
    ptr_m = (ptr_m + 1) % 64;
    send_byte(d, a);
    chk("R4 data byte ACK", int'(a), 1);
  endtask

  task automatic rbyte(input logic mack, input string req);
    logic [7:0] d, e;
    e = (ptr_m < TR) ? shadow_m[ptr_m] : mem_m[ptr_m];
    recv_byte(mack, d);
    chk(req, int'(d), int'(e));
    ptr_m = (ptr_m + 1) % 64;
  endtask

  initial begin
    logic a, s;
    logic [7:0] d;
    for (int i = 0; i < 64; i++) mem_m[i] = 0;
    repeat (10) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R12 sda_pull after reset", int'(sda_pull), 0);
    chk("R12 wr_en after reset", int'(wr_en), 0);
    chk("R12 snap_load after reset", int'(snap_load), 0);

    // R12 pointer at 0, R2 read address, R5/R8 shadow data
    do_start(); dev(1'b1, "R2 read address ACK");
    rbyte(1'b1, "R12 read from pointer 0 (shadow)");
    rbyte(1'b0, "R5 second read byte");
    do_stop();

    // R4 write sequence
    do_start(); dev(1'b0, "R2 write address ACK");
    setptr(8); wbyte(8'hA5); wbyte(8'h3C); wbyte(8'h00);
    do_stop();

    // R7 repeated start, R9 stored locations
    do_start(); dev(1'b0, "R7 write address ACK"); setptr(8);
    do_start(); dev(1'b1, "R7 read after repeated START");
    rbyte(1'b1, "R9 location 8"); rbyte(1'b1, "R9 location 9"); rbyte(1'b0, "R9 location 10");
    do_stop();

    // R3 mismatched address
    do_start(); send_byte(8'h52, a); chk("R3 mismatched address NACK", int'(a), 0);
    send_byte(8'h77, a); chk("R3 byte after mismatch NACK", int'(a), 0);
    do_stop();

    // R10 wrap
    do_start(); dev(1'b0, "R10 write address ACK"); setptr(63); wbyte(8'h11); wbyte(8'h22);
    chk("R10 model pointer wrapped", ptr_m, 1);
    do_start(); dev(1'b0, "R10 addr"); setptr(62);
    do_start(); dev(1'b1, "R10 read addr");
    rbyte(1'b1, "R10 location 62"); rbyte(1'b1, "R10 location 63");
    rbyte(1'b0, "R10 wrapped to location 0");
    do_stop();

    // R8 coherence while live time changes mid-read
    do_start(); dev(1'b0, "R8 addr"); setptr(0);
    do_start(); dev(1'b1, "R8 read addr");
    rbyte(1'b1, "R8 shadow byte 0");
    tl = ~tl;
    rbyte(1'b1, "R8 shadow byte 1 after live change");
    tl = tl + 64'h0f0f;
    rbyte(1'b0, "R8 shadow byte 2 after live change");
    // R6 silence after NACK
    recv_byte(1'b0, d); chk("R6 SDA released after NACK", int'(d), 8'hFF);
    do_stop();

    // R11 timeout during ACK
    do_start(); dev(1'b0, "R11 addr"); setptr(20);
    exp_q.push_back({AW'(20), 8'h5A}); mem_m[20] = 8'h5A;
    for (int i = 7; i >= 0; i--) clk_bit(d[0] ^ d[0] ^ ((8'h5A >> i) & 1), s);
    chk("R4 ACK driven before stall", int'(sda_pull), 1);
    repeat (TO + 40) @(negedge clk);
    chk("R11 SDA released after timeout", int'(sda_pull), 0);
    clk_bit(1'b1, s); chk("R11 ninth clock not ACKed", int'(s), 1);
    send_byte(8'h66, a); chk("R11 byte after timeout NACK", int'(a), 0);
    do_stop();
    do_start(); dev(1'b0, "R11 addr"); setptr(21);
    do_start(); dev(1'b1, "R11 read addr");
    rbyte(1'b0, "R11 location 21 untouched");
    do_stop();

    // R1 stop ends transfer
    do_start(); dev(1'b0, "R1 addr"); setptr(30); do_stop();
    send_byte(8'h99, a); chk("R1 byte after STOP NACK", int'(a), 0);
    do_stop();

    repeat (20) @(negedge clk);
    chk("R4 all expected writes seen", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL R1 watchdog: actual hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end
endmodule